// File: doc/BRIEF.md
# Nibble-Masked Single-Port Synchronous RAM

This block is a synthesizable behavioural model of a single-port static RAM bank. The bank holds 16-bit words, and one address port serves both reads and writes on a single clock. A write stores only the 4-bit lanes chosen by a lane mask. Every access is qualified by a chip select. Three power controls can also block access: light sleep, deep sleep and an active-low power input. The full-size bank is built with `ADDR_W = 14`, which gives 16,384 words. The default value is smaller so that quick elaboration stays light.

Stored words are never loaded at configuration time. The model tracks, for each 4-bit lane of each word, whether that lane has been written since the last reset or the last loss of power. A lane that has not been written reads as the matching lane of the `FILL` pattern instead of stale data. This makes "undefined" contents repeatable. It also makes a power loss visible, because every word reverts to the pattern.

The block suits a processor scratchpad or a frame buffer that needs sub-byte writes. Software must initialise any words it relies on.

Top module: `nibble_spram`

## Requirements
- R1: During and right after the synchronous active-low reset, `rdata` is 16'h0000.
- R2: In a cycle with `cs`=1, `standby`=0, `sleep`=0, `pwr_on`=1 and `we`=0, the word at `addr` appears on `rdata` one clock later. Back-to-back reads of different addresses return their own words.
- R3: Mask bit i (LSB is bit 0) stores write-data bits [4i+3:4i] and leaves the other lanes of the word intact. For example, mask 4'b1100 writes only the upper byte.
- R4: A write cycle with mask 4'b0000 leaves the addressed word unchanged.
- R5: A write takes place only when `we` and `cs` are both 1. With `cs`=0, the word is not changed.
- R6: In a write cycle, `rdata` keeps its previous value. Written data is not forwarded.
- R7: With `cs`=0, `rdata` holds its value in the next cycle.
- R8: While `standby` or `sleep` is 1, no read or write takes place and `rdata` holds. Stored words are retained through the low-power period.
- R9: While `pwr_on` is 0, no access takes place and `rdata` holds. After any cycle with `pwr_on` low, every lane of every word reads as its `FILL` lane until it is written again.
- R10: A lane that has not been written since reset or since the last power-off reads as the matching lane of `FILL` (default 16'hA5C3). The written lanes of a partly written word read their stored values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all transfers |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write data |
| wmask | input | 4 | Lane write mask, one bit per 4-bit lane |
| we | input | 1 | Write enable, active high |
| cs | input | 1 | Chip select, active high |
| standby | input | 1 | Light sleep request, active high |
| sleep | input | 1 | Deep sleep request, active high |
| pwr_on | input | 1 | Power present, active high (low = powered off) |
| rdata | output | 16 | Registered read data |

## Verification
The hardest state to reach is a word whose lanes differ in provenance. Some lanes are written and others still carry the pattern, and a power drop must then turn all of them back into the pattern. The stimulus gets there in stages. It first writes a word lane by lane with different masks. It then writes a single lane of a fresh address at the top of the range. It holds `pwr_on` low for one cycle and reads both words back. The read values are predicted from a lane-level model kept in the bench.

// File: rtl/nibble_spram_pkg.sv
// Package: shared constants for the lane-masked RAM.
// Assumes the data width is an exact multiple of the lane width.
package nibble_spram_pkg;
    localparam int LANE_W  = 4;
    localparam int DATA_W  = 16;
    localparam int N_LANES = DATA_W / LANE_W;

    typedef logic [DATA_W-1:0]  word_t;
    typedef logic [N_LANES-1:0] lane_mask_t;
endpackage

// File: rtl/nibble_spram_ctrl.sv
// Access qualifier: combines chip select, the three power controls, write
// enable and the lane mask into per-lane write strobes, a read strobe and a
// wipe request. Assumes all inputs are synchronous to the RAM clock.
module nibble_spram_ctrl
    import nibble_spram_pkg::*;
(
    input  logic       cs,
    input  logic       we,
    input  logic       standby,
    input  logic       sleep,
    input  logic       pwr_on,
    input  lane_mask_t wmask,
    output logic       rd_fire,
    output lane_mask_t wr_lane,
    output logic       wipe
);
    logic access_ok;

    // Decide whether this cycle may touch the array at all.
    always_comb begin
        access_ok = cs && !standby && !sleep && pwr_on;
        rd_fire   = access_ok && !we;
        wipe      = !pwr_on;
    end

    // Fan the write qualifier out to each lane.
    for (genvar g = 0; g < N_LANES; g++) begin : g_wr
        assign wr_lane[g] = access_ok && we && wmask[g];
    end
endmodule

// File: rtl/nibble_spram_lane.sv
// One 4-bit lane of the RAM: storage, a written-since-wipe flag per word,
// and the registered lane of the read output. Assumes the wipe and write
// strobes are never asserted together (the controller blocks writes while
// power is off). Storage itself is not reset.
module nibble_spram_lane #(
    parameter int           ADDR_W  = 10,
    parameter int           LANE_W  = 4,
    parameter logic [3:0]   FILL_LN = 4'h0,
    localparam int          DEPTH   = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wipe,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANE_W-1:0] wd,
    output logic [LANE_W-1:0] rq
);
    logic [LANE_W-1:0] cells [DEPTH];
    logic [DEPTH-1:0]  written;

    // Store the lane value on a qualified write.
    always_ff @(posedge clk) begin
        if (wr_en) cells[addr] <= wd;
    end

    // Track which words hold a defined lane; reset and power loss clear all.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe) written <= '0;
        else if (wr_en)     written[addr] <= 1'b1;
    end

    // Register the read lane, substituting the pattern for undefined lanes.
    always_ff @(posedge clk) begin
        if (!rst_n)     rq <= '0;
        else if (rd_en) rq <= written[addr] ? cells[addr] : FILL_LN[LANE_W-1:0];
    end
endmodule

// File: rtl/nibble_spram.sv
// Top: single-port synchronous RAM with 4-bit lane write masking, chip
// select, light/deep sleep and active-low power input. Reads are registered
// (one-cycle latency) and the output holds on every cycle that is not a
// qualified read. Assumes ADDR_W sets the depth (14 for the full bank).
module nibble_spram
    import nibble_spram_pkg::*;
#(
    parameter int    ADDR_W = 10,
    parameter word_t FILL   = 16'hA5C3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    input  logic [3:0]        wmask,
    input  logic              we,
    input  logic              cs,
    input  logic              standby,
    input  logic              sleep,
    input  logic              pwr_on,
    output logic [15:0]       rdata
);
    logic       rd_fire;
    logic       wipe;
    lane_mask_t wr_lane;

    nibble_spram_ctrl u_ctrl (
        .cs      (cs),
        .we      (we),
        .standby (standby),
        .sleep   (sleep),
        .pwr_on  (pwr_on),
        .wmask   (wmask),
        .rd_fire (rd_fire),
        .wr_lane (wr_lane),
        .wipe    (wipe)
    );

    // One storage lane per 4-bit slice of the word.
    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        nibble_spram_lane #(
            .ADDR_W  (ADDR_W),
            .LANE_W  (LANE_W),
            .FILL_LN (FILL[g*LANE_W +: LANE_W])
        ) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .wipe  (wipe),
            .wr_en (wr_lane[g]),
            .rd_en (rd_fire),
            .addr  (addr),
            .wd    (wdata[g*LANE_W +: LANE_W]),
            .rq    (rdata[g*LANE_W +: LANE_W])
        );
    end

    // R6
    write_no_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && we) |=> $stable(rdata));

    // R7
    deselect_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> $stable(rdata));

    // R8
    lowpower_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (standby || sleep) |=> $stable(rdata));

    // R9
    poweroff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |=> $stable(rdata));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (rdata == 16'h0000));
endmodule

// File: tb/sim_nibble_spram.sv
// Scoreboard bench: the driver applies one operation per cycle and queues the
// rdata value expected after that edge; the monitor pops and compares.
module sim_nibble_spram;
    localparam int          PERIOD = 10;
    localparam int          AW     = 10;
    localparam logic [15:0] FILL   = 16'hA5C3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [15:0]   wdata = '0;
    logic [3:0]    wmask = '0;
    logic          we = 1'b0, cs = 1'b0, standby = 1'b0, sleep = 1'b0, pwr_on = 1'b1;
    logic [15:0]   rdata;

    int total = 0;
    int bad   = 0;
    logic [15:0] exp_q [$];
    string       tag_q [$];
    logic [15:0] bm_data [int];
    logic [3:0]  bm_vld  [int];
    logic [15:0] exp_now = 16'h0000;
    logic [15:0] pe;
    string       pt;

    nibble_spram #(.ADDR_W(AW), .FILL(FILL)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wmask(wmask),
        .we(we), .cs(cs), .standby(standby), .sleep(sleep), .pwr_on(pwr_on),
        .rdata(rdata)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic logic [15:0] model_read(int a);
        logic [15:0] v;
        for (int i = 0; i < 4; i++) begin
            if (bm_vld.exists(a) && bm_vld[a][i]) v[i*4 +: 4] = bm_data[a][i*4 +: 4];
            else                                  v[i*4 +: 4] = FILL[i*4 +: 4];
        end
        return v;
    endfunction

    // Driver: apply one cycle of stimulus and queue the predicted output.
    task automatic op(bit w, bit c, bit sb, bit sl, bit pw, int a,
                      logic [15:0] d, logic [3:0] m, string tag);
        bit acc;
        @(negedge clk);
        we = w; cs = c; standby = sb; sleep = sl; pwr_on = pw;
        addr = a[AW-1:0]; wdata = d; wmask = m;
        acc = c && !sb && !sl && pw;
        if (!pw) begin
            bm_vld.delete();
            bm_data.delete();
        end
        if (acc && w) begin
            if (!bm_vld.exists(a)) begin bm_vld[a] = 4'b0000; bm_data[a] = 16'h0000; end
            for (int i = 0; i < 4; i++) begin
                if (m[i]) begin
                    bm_data[a][i*4 +: 4] = d[i*4 +: 4];
                    bm_vld[a][i] = 1'b1;
                end
            end
        end else if (acc) begin
            exp_now = model_read(a);
        end
        exp_q.push_back(exp_now);
        tag_q.push_back(tag);
    endtask

    task automatic rd(int a, string tag);
        op(0, 1, 0, 0, 1, a, 16'h0000, 4'h0, tag);
    endtask

    task automatic wr(int a, logic [15:0] d, logic [3:0] m, string tag);
        op(1, 1, 0, 0, 1, a, d, m, tag);
    endtask

    // Monitor: compare rdata a quarter period after each rising edge.
    always @(posedge clk) begin
        #(PERIOD/4);
        if (exp_q.size() > 0) begin
            pe = exp_q.pop_front();
            pt = tag_q.pop_front();
            total++;
            if (rdata !== pe) begin
                bad++;
                $display("FAIL %s: rdata=%h expected=%h", pt, rdata, pe);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        total++;
        if (rdata !== 16'h0000) begin
            bad++;
            $display("FAIL R1: rdata=%h expected=%h", rdata, 16'h0000);
        end
        rst_n = 1'b1;

        rd(5, "R10 unwritten word");
        wr(5, 16'h1234, 4'b1111, "R6 full write holds");
        rd(5, "R2 read after write");
        wr(5, 16'hABCD, 4'b1100, "R3 upper byte mask");
        rd(5, "R3 upper byte merged");
        wr(1023, 16'hEEEF, 4'b0001, "R3 single lane top address");
        rd(1023, "R10 partly written word");
        wr(5, 16'hFFFF, 4'b0000, "R4 empty mask");
        rd(5, "R4 word unchanged");
        rd(1023, "R2 back to back a");
        rd(5, "R2 back to back b");
        wr(6, 16'h7777, 4'b1111, "R6 no forwarding");
        rd(6, "R2 read addr 6");
        op(1, 0, 0, 0, 1, 5, 16'h0000, 4'b1111, "R5 write without cs");
        rd(5, "R5 word kept");
        op(0, 0, 0, 0, 1, 1023, 16'h0000, 4'h0, "R7 deselected read holds");
        op(0, 1, 1, 0, 1, 1023, 16'h0000, 4'h0, "R8 standby read holds");
        op(1, 1, 1, 0, 1, 5, 16'h0000, 4'b1111, "R8 standby write blocked");
        op(0, 1, 0, 1, 1, 6, 16'h0000, 4'h0, "R8 sleep read holds");
        op(1, 1, 0, 1, 1, 6, 16'h0000, 4'b1111, "R8 sleep write blocked");
        rd(5, "R8 contents retained a");
        rd(6, "R8 contents retained b");
        op(1, 1, 0, 0, 0, 5, 16'h0000, 4'b1111, "R9 powered off holds");
        rd(5, "R9 word lost after power off");
        rd(1023, "R9 top word lost after power off");
        wr(6, 16'h9C00, 4'b0110, "R9 rewrite after power");
        rd(6, "R10 lanes after rewrite");

        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule